// File: doc/BRIEF.md
# Bidirectional Gray-Code Major-State Sequencer

This block holds a two-bit controller state and steps it around a ring of four major states. Each step goes one way or the other, as chosen by a step-left or a step-right strobe. The new value of each state bit is formed only from the old value of the other bit and the step direction. No adder or counter is involved. As a result, every move flips exactly one bit and the walk can always be undone by one step the other way.

Besides the two state bits, the block drives four registered active-high major-state lines, exactly one of which is high at any time. Control logic around it pulses a strobe for one cycle to move the state. If both strobes arrive together, the state is left alone and a one-cycle clash flag is raised.

Top module: `gray_seq`

## Requirements
- R1: While the synchronous reset is high at a rising clock edge, the block sets both state bits to 0, drives state_line to 4'b0001 and drives cmd_clash to 0.
- R2: state_line is always one-hot. Bit index 2*st_hi + st_lo of state_line is the one that is set, so bit 0 means major state 0 and bit 3 means major state 3.
- R3: A step-right edge (step_r=1, step_l=0) loads st_hi with the old st_lo and st_lo with the inverse of the old st_hi. From state 0, repeated right steps visit major states 1, 3, 2, 0.
- R4: A step-left edge (step_l=1, step_r=0) loads st_hi with the inverse of the old st_lo and st_lo with the old st_hi. From state 0, repeated left steps visit major states 2, 3, 1, 0.
- R5: An edge with neither strobe high leaves st_hi, st_lo and state_line unchanged.
- R6: An edge with both strobes high leaves the state unchanged and sets cmd_clash to 1 for the following cycle only. At every other edge cmd_clash is 0.
- R7: Every left or right step changes exactly one of the two state bits.
- R8: Four consecutive steps in the same direction return the block to the state it started from.
- R9: From every major state, a right step followed by a left step returns to the start state. The same holds for a left step followed by a right step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_l | input | 1 | Step-left strobe |
| step_r | input | 1 | Step-right strobe |
| st_hi | output | 1 | State bit of weight 2 |
| st_lo | output | 1 | State bit of weight 1 |
| state_line | output | 4 | One-hot major-state lines, bit n = state n |
| cmd_clash | output | 1 | One-cycle flag: both strobes were sampled high |

## Verification
Two functions can fall in the same cycle: a step left and a step right, requested by both strobes at one edge. The bench provokes this from every one of the four major states. It judges that the state bits and lines hold and that cmd_clash is high for exactly that one cycle. It then confirms that the next ordinary step still follows the R3 and R4 rules.

// File: rtl/gray_seq_pkg.sv
package gray_seq_pkg;
  localparam int unsigned SEQ_BITS  = 2;
  localparam int unsigned SEQ_LINES = 1 << SEQ_BITS;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_RIGHT = 2'b01,
    CMD_LEFT  = 2'b10,
    CMD_BOTH  = 2'b11
  } seq_cmd_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } seq_state_t;
endpackage

// File: rtl/gray_seq_next.sv
module gray_seq_next
  import gray_seq_pkg::*;
(
  input  seq_state_t cur,
  input  logic       step_l,
  input  logic       step_r,
  output seq_state_t nxt,
  output logic       clash
);
  seq_cmd_e cmd;

  always_comb begin
    cmd   = seq_cmd_e'({step_l, step_r});
    nxt   = cur;
    clash = 1'b0;
    unique case (cmd)
      CMD_RIGHT: begin
        nxt.hi = cur.lo;
        nxt.lo = ~cur.hi;
      end
      CMD_LEFT: begin
        nxt.hi = ~cur.lo;
        nxt.lo = cur.hi;
      end
      CMD_BOTH:  clash = 1'b1;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/gray_seq_decode.sv
module gray_seq_decode #(
  parameter int unsigned LINES = 4,
  localparam int unsigned CODE_W = $clog2(LINES)
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/gray_seq.sv
module gray_seq
  import gray_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_l,
  input  logic                 step_r,
  output logic                 st_hi,
  output logic                 st_lo,
  output logic [SEQ_LINES-1:0] state_line,
  output logic                 cmd_clash
);
  seq_state_t           cur_q, nxt;
  logic                 clash_d;
  logic [SEQ_LINES-1:0] line_d;

  gray_seq_next u_next (
    .cur    (cur_q),
    .step_l (step_l),
    .step_r (step_r),
    .nxt    (nxt),
    .clash  (clash_d)
  );

  gray_seq_decode #(.LINES(SEQ_LINES)) u_dec (
    .code  ({nxt.hi, nxt.lo}),
    .lines (line_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      state_line <= SEQ_LINES'(1);
      cmd_clash  <= 1'b0;
    end else begin
      cur_q      <= nxt;
      state_line <= line_d;
      cmd_clash  <= clash_d;
    end
  end

  assign st_hi = cur_q.hi;
  assign st_lo = cur_q.lo;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!st_hi && !st_lo && state_line == SEQ_LINES'(1) && !cmd_clash));

  a_r2_line_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_line) == 1 && state_line[{st_hi, st_lo}]);

  a_r3_step_right: assert property (@(posedge clk) disable iff (rst)
    (step_r && !step_l) |=> (st_hi == $past(st_lo) && st_lo == !$past(st_hi)));

  a_r4_step_left: assert property (@(posedge clk) disable iff (rst)
    (step_l && !step_r) |=> (st_hi == !$past(st_lo) && st_lo == $past(st_hi)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_l && !step_r) |=> ($stable(st_hi) && $stable(st_lo) && $stable(state_line)));

  a_r6_clash_hold: assert property (@(posedge clk) disable iff (rst)
    (step_l && step_r) |=> (cmd_clash && $stable(st_hi) && $stable(st_lo)));

  a_r6_clash_only: assert property (@(posedge clk) disable iff (rst)
    !(step_l && step_r) |=> !cmd_clash);

  a_r7_one_bit_flip: assert property (@(posedge clk) disable iff (rst)
    (step_l ^ step_r) |=> $countones({st_hi, st_lo} ^ $past({st_hi, st_lo})) == 1);
endmodule

// File: tb/sim_gray_seq.sv
module sim_gray_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_l = 1'b0;
  logic       step_r = 1'b0;
  logic       st_hi, st_lo, cmd_clash;
  logic [3:0] state_line;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int m_hi = 0;
  int m_lo = 0;

  always #5 clk = ~clk;

  gray_seq u0 (
    .clk(clk), .rst(rst), .step_l(step_l), .step_r(step_r),
    .st_hi(st_hi), .st_lo(st_lo), .state_line(state_line), .cmd_clash(cmd_clash)
  );

  task automatic check(input string req, input int eh, input int el, input int ec);
    logic [3:0] el_line;
    el_line = 4'(1 << (2 * eh + el));
    checks++;
    if (st_hi !== 1'(eh) || st_lo !== 1'(el) || state_line !== el_line || cmd_clash !== 1'(ec)) begin
      errors++;
      $display("FAIL %s: got hi=%b lo=%b line=%b clash=%b, expected hi=%0d lo=%0d line=%b clash=%0d",
               req, st_hi, st_lo, state_line, cmd_clash, eh, el, el_line, ec);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  // Apply one command for one edge, then sample at the following negedge.
  task automatic apply(input bit l, input bit r, input string req);
    int ph, pl, ec;
    ph = m_hi; pl = m_lo; ec = 0;
    step_l = l; step_r = r;
    @(negedge clk);
    step_l = 1'b0; step_r = 1'b0;
    if (r && !l) begin m_hi = pl; m_lo = 1 - ph; end       // R3
    else if (l && !r) begin m_hi = 1 - pl; m_lo = ph; end  // R4
    else if (l && r) ec = 1;                               // R6
    check(req, m_hi, m_lo, ec);
    if (l ^ r) check_eq("R7 one bit flips", ((ph ^ m_hi) + (pl ^ m_lo)), 1);
  endtask

  task automatic goto_state(input int s);
    for (int k = 0; k < 4 && (2 * m_hi + m_lo) != s; k++) apply(1'b0, 1'b1, "R3 walk");
  endtask

  initial begin
    int start;
    repeat (3) @(negedge clk);
    check("R1 reset", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 0, 0, 0);

    // R3 / R8: right walk 1,3,2,0
    apply(1'b0, 1'b1, "R3 right"); check_eq("R3 order", 2 * m_hi + m_lo, 1);
    apply(1'b0, 1'b1, "R3 right"); check_eq("R3 order", 2 * m_hi + m_lo, 3);
    apply(1'b0, 1'b1, "R3 right"); check_eq("R3 order", 2 * m_hi + m_lo, 2);
    apply(1'b0, 1'b1, "R3 right"); check_eq("R8 right ring", 2 * m_hi + m_lo, 0);
    // R4 / R8: left walk 2,3,1,0
    apply(1'b1, 1'b0, "R4 left"); check_eq("R4 order", 2 * m_hi + m_lo, 2);
    apply(1'b1, 1'b0, "R4 left"); check_eq("R4 order", 2 * m_hi + m_lo, 3);
    apply(1'b1, 1'b0, "R4 left"); check_eq("R4 order", 2 * m_hi + m_lo, 1);
    apply(1'b1, 1'b0, "R4 left"); check_eq("R8 left ring", 2 * m_hi + m_lo, 0);

    for (int s = 0; s < 4; s++) begin
      goto_state(s);
      start = 2 * m_hi + m_lo;
      // R8 from every start, both directions
      for (int k = 0; k < 4; k++) apply(1'b0, 1'b1, "R8 right x4");
      check_eq("R8 right return", 2 * m_hi + m_lo, start);
      for (int k = 0; k < 4; k++) apply(1'b1, 1'b0, "R8 left x4");
      check_eq("R8 left return", 2 * m_hi + m_lo, start);
      // R9 undo
      apply(1'b0, 1'b1, "R9 right"); apply(1'b1, 1'b0, "R9 left undo");
      check_eq("R9 left undoes right", 2 * m_hi + m_lo, start);
      apply(1'b1, 1'b0, "R9 left"); apply(1'b0, 1'b1, "R9 right undo");
      check_eq("R9 right undoes left", 2 * m_hi + m_lo, start);
      // R5 idle
      apply(1'b0, 1'b0, "R5 idle hold");
      apply(1'b0, 1'b0, "R5 idle hold");
      // R6 clash, held twice then cleared
      apply(1'b1, 1'b1, "R6 clash hold");
      apply(1'b1, 1'b1, "R6 clash repeat");
      apply(1'b0, 1'b0, "R6 clash clears");
      apply(1'b1, 1'b1, "R6 clash hold");
      apply(1'b1, 1'b0, "R6 step after clash");
      apply(1'b0, 1'b1, "R6 step after clash");
      check_eq("R2 line index", $clog2(int'(state_line)), 2 * m_hi + m_lo);
    end

    // R1 mid-run reset
    goto_state(3);
    rst = 1'b1; step_r = 1'b1; step_l = 1'b1;
    @(negedge clk);
    step_r = 1'b0; step_l = 1'b0;
    m_hi = 0; m_lo = 0;
    check("R1 reset over strobes", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after second release", 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule